// File: doc/BRIEF.md
# Memory Data Bus Line Tester

This engine checks the data lines of an external 64-bit memory port for stuck, shorted, open and floating lines. After a one-cycle `start` pulse it takes the region base address. It then works through a fixed list of test words. For each word it does four things in order: it writes the word to the base address, it writes a fixed decoy word to the next word address, it reads the base address back, and it compares the result with the word.

The decoy write places a different value on the data bus between the write and the read-back. A line that floats therefore cannot hold the value just written and make it look correct.

The test words cover every pairing of neighbouring bits, whatever the board routing is. This works because each word toggles the bits on a period of a different power of two. The list also holds the inverse of each word.

The engine stops at the first mismatch and raises a sticky `fail` flag. It holds the failing address, the word written and the word read back, with each 64-bit value given as two 32-bit halves.

Top module: `mem_dataline_tester`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done`, `fail` and `mem_req` are all 0.
- R2: The pattern writes use the base address. They come in this order: for k = 0..5, a word whose bit i equals bit k of the index i (0xAAAA…, 0xCCCC…, 0xF0F0…, 0xFF00…, 0xFFFF0000…, 0xFFFFFFFF00000000). These are followed by the bitwise inverses of the same six words, taken from k = 5 down to k = 0.
- R3: Between each pattern write and its read-back, one write of 0x0123456789ABCDEF goes to base address + 1.
- R4: The base address is read exactly once per pattern. The engine waits for `mem_rvalid` however many cycles it takes. The single captured word is used both for the compare and for the report.
- R5: Each pattern takes 4 cycles plus the number of cycles from the read request to `mem_rvalid`. When all twelve patterns match, `busy` stays high for twelve such periods, `done` pulses and `fail` stays 0.
- R6: On the first mismatch the engine stops. No further memory requests are made, `done` pulses and `fail` rises.
- R7: On a failure, `err_addr` holds the base address. `err_exp_hi` and `err_exp_lo` hold the upper and lower 32 bits of the word written. `err_act_hi` and `err_act_lo` hold the upper and lower 32 bits of the word read.
- R8: `fail` stays at 1 until the next accepted `start`, which clears it.
- R9: A `start` pulse that arrives while `busy` is high has no effect on the ongoing run.
- R10: `done` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| base_addr | input | ADDR_W | Word address of the target location, sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| mem_req | output | 1 | Memory access request, one cycle per access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data strobe |
| err_addr | output | ADDR_W | Failing address |
| err_exp_hi | output | DATA_W/2 | Upper half of the word written |
| err_exp_lo | output | DATA_W/2 | Lower half of the word written |
| err_act_hi | output | DATA_W/2 | Upper half of the word read |
| err_act_lo | output | DATA_W/2 | Lower half of the word read |

## Verification
The bench uses a memory model with injected faults:
- A single stuck-at-zero line that escapes the first six words. A design that checked only the non-inverted words would pass it.
- A stuck-at-one line.
- A wired-AND short between two lines that are not neighbours.
- A single floating line.
- A whole floating byte lane. Here the expected read-back carries the decoy byte in that lane.

A floating line returns whatever was last on the bus. A design that skipped the decoy write, or that read before it, would therefore see its own pattern echoed and miss the fault. Each case checks the exact failing word, the number of reads and the run length in cycles. A design that read twice, or that kept going after a mismatch, would show extra reads or a longer `busy` period. Two further cases send a second `start` in the middle of a run and check that `fail` stays set between runs.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_PAT,
      ST_WR_DECOY,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_CMP,
      ST_DONE
   } mdt_state_e;
endpackage

// File: rtl/mdt_pattern_gen.sv
// Builds the walking-period test words and their inverses from DATA_W.
module mdt_pattern_gen #(
   parameter int DATA_W = 64,
   localparam int LOG_W = $clog2(DATA_W),
   localparam int NUM_PAT = 2 * LOG_W,
   localparam int IDX_W = $clog2(NUM_PAT)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] pattern
);
   logic [DATA_W-1:0] base_pat [LOG_W];
   logic [DATA_W-1:0] pat_tab  [NUM_PAT];

   for (genvar k = 0; k < LOG_W; k++) begin : g_base
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign base_pat[k][i] = ((i >> k) & 1) != 0;
      end
   end

   for (genvar j = 0; j < NUM_PAT; j++) begin : g_tab
      if (j < LOG_W) begin : g_fwd
         assign pat_tab[j] = base_pat[j];
      end else begin : g_inv
         assign pat_tab[j] = ~base_pat[NUM_PAT-1-j];
      end
   end

   always_comb begin
      pattern = '0;
      for (int j = 0; j < NUM_PAT; j++) begin
         if (idx == IDX_W'(j)) pattern = pat_tab[j];
      end
   end
endmodule

// File: rtl/mdt_ctrl.sv
// Sequencer: write pattern, write decoy, one read, compare.
module mdt_ctrl import mdt_pkg::*; #(
   parameter int NUM_PAT = 12,
   localparam int IDX_W = $clog2(NUM_PAT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rvalid,
   input  logic             match,
   output logic             busy,
   output logic             done,
   output logic             mem_req,
   output logic             mem_we,
   output logic             use_decoy,
   output logic             accept,
   output logic             cap_en,
   output logic             fail_set,
   output logic [IDX_W-1:0] idx
);
   mdt_state_e state, nxt;
   logic       last;

   assign last      = idx == IDX_W'(NUM_PAT - 1);
   assign accept    = (state == ST_IDLE) && start;
   assign cap_en    = (state == ST_RD_WAIT) && rvalid;
   assign fail_set  = (state == ST_CMP) && !match;
   assign busy      = (state != ST_IDLE) && (state != ST_DONE);
   assign done      = state == ST_DONE;
   assign mem_req   = (state == ST_WR_PAT) || (state == ST_WR_DECOY) || (state == ST_RD_REQ);
   assign mem_we    = (state == ST_WR_PAT) || (state == ST_WR_DECOY);
   assign use_decoy = state == ST_WR_DECOY;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:     if (start) nxt = ST_WR_PAT;
         ST_WR_PAT:   nxt = ST_WR_DECOY;
         ST_WR_DECOY: nxt = ST_RD_REQ;
         ST_RD_REQ:   nxt = ST_RD_WAIT;
         ST_RD_WAIT:  if (rvalid) nxt = ST_CMP;
         ST_CMP:      nxt = (!match || last) ? ST_DONE : ST_WR_PAT;
         ST_DONE:     nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         state <= nxt;
         if (accept) idx <= '0;
         else if ((state == ST_CMP) && match && !last) idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/mdt_capture.sv
// Single read-back capture and sticky failure report.
module mdt_capture #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] rdata,
   input  logic              fail_set,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] expected,
   output logic [DATA_W-1:0] rd_q,
   output logic              fail,
   output logic [ADDR_W-1:0] err_addr,
   output logic [DATA_W-1:0] err_exp,
   output logic [DATA_W-1:0] err_act
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q     <= '0;
         fail     <= 1'b0;
         err_addr <= '0;
         err_exp  <= '0;
         err_act  <= '0;
      end else begin
         if (cap_en) rd_q <= rdata;
         if (clear) begin
            fail     <= 1'b0;
            err_addr <= '0;
            err_exp  <= '0;
            err_act  <= '0;
         end else if (fail_set) begin
            fail     <= 1'b1;
            err_addr <= addr;
            err_exp  <= expected;
            err_act  <= rd_q;
         end
      end
   end
endmodule

// File: rtl/mem_dataline_tester.sv
module mem_dataline_tester #(
   parameter int                    DATA_W = 64,
   parameter int                    ADDR_W = 16,
   parameter logic [DATA_W-1:0]     DECOY  = 64'h0123_4567_89AB_CDEF,
   localparam int                   LOG_W  = $clog2(DATA_W),
   localparam int                   NUM_PAT = 2 * LOG_W,
   localparam int                   IDX_W  = $clog2(NUM_PAT),
   localparam int                   HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid,
   output logic [ADDR_W-1:0] err_addr,
   output logic [HALF_W-1:0] err_exp_hi,
   output logic [HALF_W-1:0] err_exp_lo,
   output logic [HALF_W-1:0] err_act_hi,
   output logic [HALF_W-1:0] err_act_lo
);
   if ((1 << LOG_W) != DATA_W || DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be a power of two, at least 4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic              use_decoy, accept, cap_en, fail_set, match;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] pattern, rd_q, err_exp, err_act;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      base_q <= '0;
      else if (accept) base_q <= base_addr;
   end

   mdt_pattern_gen #(.DATA_W(DATA_W)) i_pat (
      .idx     (idx),
      .pattern (pattern)
   );

   mdt_ctrl #(.NUM_PAT(NUM_PAT)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rvalid    (mem_rvalid),
      .match     (match),
      .busy      (busy),
      .done      (done),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .use_decoy (use_decoy),
      .accept    (accept),
      .cap_en    (cap_en),
      .fail_set  (fail_set),
      .idx       (idx)
   );

   mdt_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .cap_en   (cap_en),
      .rdata    (mem_rdata),
      .fail_set (fail_set),
      .addr     (base_q),
      .expected (pattern),
      .rd_q     (rd_q),
      .fail     (fail),
      .err_addr (err_addr),
      .err_exp  (err_exp),
      .err_act  (err_act)
   );

   assign match      = rd_q == pattern;
   assign mem_addr   = use_decoy ? base_q + 1'b1 : base_q;
   assign mem_wdata  = use_decoy ? DECOY : pattern;
   assign err_exp_hi = err_exp[DATA_W-1:HALF_W];
   assign err_exp_lo = err_exp[HALF_W-1:0];
   assign err_act_hi = err_act[DATA_W-1:HALF_W];
   assign err_act_lo = err_act[HALF_W-1:0];
endmodule

// File: rtl/mdt_checker.sv
module mdt_checker #(
   parameter int                DATA_W = 64,
   parameter int                ADDR_W = 16,
   parameter logic [DATA_W-1:0] DECOY  = 64'h0123_4567_89AB_CDEF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_rvalid
);
   logic rd_req, wr_req, rd_pend;
   assign rd_req = mem_req && !mem_we;
   assign wr_req = mem_req && mem_we;

   always_ff @(posedge clk) begin
      if (!rst_n)          rd_pend <= 1'b0;
      else if (rd_req)     rd_pend <= 1'b1;
      else if (mem_rvalid) rd_pend <= 1'b0;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !done && !fail && !mem_req); // R1
   AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> !rd_pend); // R4
   AST_DECOY_FIRST: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> $past(wr_req && mem_wdata == DECOY)); // R3
   AST_DECOY_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> (mem_addr + ADDR_W'(1)) == $past(mem_addr)); // R3
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) fail && !start |=> fail); // R8
endmodule

bind mem_dataline_tester mdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DECOY(DECOY)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .fail       (fail),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_rvalid (mem_rvalid)
);

// File: tb/test_mem_dataline_tester.sv
module test_mem_dataline_tester;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] DECOY_W = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] EXP_PAT [12] = '{
      64'hAAAA_AAAA_AAAA_AAAA, 64'hCCCC_CCCC_CCCC_CCCC, 64'hF0F0_F0F0_F0F0_F0F0,
      64'hFF00_FF00_FF00_FF00, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_0000_0000,
      64'h0000_0000_FFFF_FFFF, 64'h0000_FFFF_0000_FFFF, 64'h00FF_00FF_00FF_00FF,
      64'h0F0F_0F0F_0F0F_0F0F, 64'h3333_3333_3333_3333, 64'h5555_5555_5555_5555};

   // fault modes: 0 none, 1 stuck-0 range, 2 stuck-1 range, 3 wired-AND of two bits, 4 floating range
   typedef struct packed {
      logic [2:0]  mode;
      logic [5:0]  fa;
      logic [5:0]  fb;
      logic [3:0]  lat;
      logic [15:0] base;
      logic [3:0]  exp_idx;   // 12 = all pass
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 6'd0,  6'd0,  4'd1, 16'd0, 4'd12},
      '{3'd0, 6'd0,  6'd0,  4'd3, 16'd5, 4'd12},
      '{3'd1, 6'd0,  6'd0,  4'd2, 16'd2, 4'd6},
      '{3'd2, 6'd5,  6'd5,  4'd1, 16'd0, 4'd1},
      '{3'd3, 6'd0,  6'd2,  4'd2, 16'd3, 4'd1},
      '{3'd4, 6'd60, 6'd60, 4'd4, 16'd1, 4'd2},
      '{3'd4, 6'd48, 6'd55, 4'd1, 16'd0, 4'd0},
      '{3'd4, 6'd1,  6'd1,  4'd2, 16'd4, 4'd1}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] base_addr = '0;
   logic        busy, done, fail, mem_req, mem_we, mem_rvalid;
   logic [15:0] mem_addr, err_addr;
   logic [63:0] mem_wdata, mem_rdata;
   logic [31:0] err_exp_hi, err_exp_lo, err_act_hi, err_act_lo;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [2:0]  f_mode = '0;
   logic [5:0]  f_a = '0, f_b = '0;
   int          f_lat = 1;

   mem_dataline_tester i_mem_dataline_tester (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .busy(busy), .done(done), .fail(fail),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
      .err_addr(err_addr), .err_exp_hi(err_exp_hi), .err_exp_lo(err_exp_lo),
      .err_act_hi(err_act_hi), .err_act_lo(err_act_lo));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] fmask();
      logic [63:0] m = '0;
      for (int i = 0; i < 64; i++) if (i >= int'(f_a) && i <= int'(f_b)) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [63:0] wfault(logic [63:0] d);
      logic [63:0] r = d;
      logic v;
      case (f_mode)
         3'd1: r = d & ~fmask();
         3'd2: r = d | fmask();
         3'd3: begin v = d[f_a] & d[f_b]; r[f_a] = v; r[f_b] = v; end
         default: r = d;
      endcase
      return r;
   endfunction

   function automatic logic [63:0] rfault(logic [63:0] s, logic [63:0] bus);
      if (f_mode == 3'd4) return (s & ~fmask()) | (bus & fmask());
      return s;
   endfunction

   // memory model with fault injection and configurable read latency
   logic [63:0] mem [8];
   logic [63:0] last_bus, rd_word;
   logic [7:0]  rv_sh;
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) mem[i] <= '0;
         last_bus <= '0; rd_word <= '0; rv_sh <= '0;
      end else begin
         if (mem_req && mem_we) begin
            mem[mem_addr[2:0]] <= wfault(mem_wdata);
            last_bus <= mem_wdata;
         end
         if (mem_req && !mem_we) rd_word <= rfault(mem[mem_addr[2:0]], last_bus);
         rv_sh <= {rv_sh[6:0], mem_req && !mem_we};
      end
   end
   assign mem_rvalid = rv_sh[f_lat-1];
   assign mem_rdata  = rd_word;

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor
   bit mon_on = 0;
   int busy_cyc, done_cnt, rd_cnt, pw_cnt;
   always @(negedge clk) begin
      if (mon_on) begin
         if (busy) busy_cyc++;
         if (done) done_cnt++;
         if (mem_req && !mem_we) begin
            rd_cnt++;
            check(mem_addr == base_addr, "R4 read addr", 64'(mem_addr), 64'(base_addr));
         end
         if (mem_req && mem_we && mem_addr == base_addr) begin
            check(pw_cnt < 12 && mem_wdata == EXP_PAT[pw_cnt % 12], "R2 pattern order",
                  mem_wdata, EXP_PAT[pw_cnt % 12]);
            pw_cnt++;
         end
         if (mem_req && mem_we && mem_addr != base_addr)
            check(mem_addr == base_addr + 16'd1 && mem_wdata == DECOY_W, "R3 decoy write",
                  mem_wdata, DECOY_W);
      end
   end

   task automatic run(vec_t v, bit extra_start);
      int n_pat, wait_cyc;
      logic [63:0] exp_act;
      f_mode = v.mode; f_a = v.fa; f_b = v.fb; f_lat = int'(v.lat); base_addr = v.base;
      busy_cyc = 0; done_cnt = 0; rd_cnt = 0; pw_cnt = 0;
      mon_on = 1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(fail == 1'b0, "R8 fail cleared by start", 64'(fail), 64'd0);
      wait_cyc = 0;
      while (!done && wait_cyc < 400) begin
         @(negedge clk);
         wait_cyc++;
         if (extra_start && wait_cyc == 10) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      n_pat = (v.exp_idx == 4'd12) ? 12 : int'(v.exp_idx) + 1;
      exp_act = rfault(wfault(EXP_PAT[n_pat-1]), DECOY_W);
      check(done == 1'b1, "R10 done seen", 64'(done), 64'd1);
      check(fail == (v.exp_idx != 4'd12), (v.exp_idx == 4'd12) ? "R5 pass" : "R6 fail flag",
            64'(fail), 64'(v.exp_idx != 4'd12));
      check(busy_cyc == n_pat * (4 + f_lat), "R5 run length", 64'(busy_cyc), 64'(n_pat * (4 + f_lat)));
      check(rd_cnt == n_pat, "R4 one read per pattern", 64'(rd_cnt), 64'(n_pat));
      if (v.exp_idx != 4'd12) begin
         check(err_addr == v.base, "R7 err_addr", 64'(err_addr), 64'(v.base));
         check({err_exp_hi, err_exp_lo} == EXP_PAT[n_pat-1], "R7 expected halves",
               {err_exp_hi, err_exp_lo}, EXP_PAT[n_pat-1]);
         check(err_act_hi == exp_act[63:32], "R7 actual hi", 64'(err_act_hi), 64'(exp_act[63:32]));
         check(err_act_lo == exp_act[31:0], "R7 actual lo", 64'(err_act_lo), 64'(exp_act[31:0]));
      end
      repeat (6) @(negedge clk);
      mon_on = 0;
      check(done_cnt == 1, "R10 single done pulse", 64'(done_cnt), 64'd1);
      check(!busy && !mem_req, "R6 quiet after run", 64'({busy, mem_req}), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !fail && !mem_req, "R1 reset state",
            64'({busy, done, fail, mem_req}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !fail && !mem_req, "R1 after reset",
            64'({busy, done, fail, mem_req}), 64'd0);

      for (int i = 0; i < 8; i++) run(VECS[i], 1'b0);

      // R8: failure flag and report held while idle
      run(VECS[6], 1'b0);
      repeat (20) @(negedge clk);
      check(fail == 1'b1, "R8 fail held while idle", 64'(fail), 64'd1);
      check({err_act_hi, err_act_lo} == 64'hAA23_AAAA_AAAA_AAAA, "R8 report held",
            {err_act_hi, err_act_lo}, 64'hAA23_AAAA_AAAA_AAAA);

      // R9: start during a run is ignored (full length, twelve reads, one done)
      run(VECS[1], 1'b1);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule